// File: doc/BRIEF.md
# Baud clock generator and selector

This block derives the 16x-oversampled bit clock enables for a two-channel serial device from one reference clock, which is the block's own clock `clk` and is meant to run at 3.6864 MHz. Every output is a one-cycle enable pulse whose rate is 16 times the chosen bit rate. Four independent selectors drive the four outputs, in this order: channel A receive (`tick[0]`), channel A transmit (`tick[1]`), channel B receive (`tick[2]`) and channel B transmit (`tick[3]`). Each selector picks one of three sources: an entry of a fixed divider table, the output of a shared counter/timer, or its own external clock pin.

The fixed table holds 23 integer divisors of the reference clock, spread over two banks, covering 50 baud up to 115.2 kbaud. The counter/timer divides either the reference clock or a separate external clock by a 16-bit preload. Software configures the block through a small write-only register port. A new selection does not cut a pulse short: the selector keeps its old source until that source delivers its next pulse, and only then switches.

Top module: `baudClkGen`

## Requirements
- R1: After reset every selector is off, and no `tick` bit pulses until its selector has been written.
- R2: Writing address 0..3 loads the selector of lane 0..3 from `wrData[4:0]`, with the code in bits [3:0] and the bank in bit 4. A code 0..13 picks a table divisor D, and the lane then pulses every D clock cycles. Bank 0 codes 0..13 give 4608, 3072, 2095, 1713, 1536, 1152, 768, 384, 219, 192, 128, 115, 96 and 48. Bank 1 codes 0..8 give 32, 24, 16, 12, 8, 6, 4, 3 and 2, so bank 1 code 1 is 9600 baud with D=24.
- R3: Every pulse on a `tick` bit is exactly one clock cycle wide, even at the fastest rate, where the period is 2 cycles.
- R4: Code 14 (either bank) selects the counter/timer. Writing address 4 sets its 16-bit preload P from `wrData`. The timer output toggles every P counted steps, and the lane pulses once per rising edge of that output, so in reference mode the period is 2·P cycles.
- R5: Writing address 5 with `wrData[0]`=1 makes the counter/timer count rising edges of `ctExtClk` instead of reference cycles. The lane period then becomes 2·P edges of that pin. `wrData[0]`=0 returns it to reference counting.
- R6: Code 15 (either bank) selects the lane's own pin `extClk[i]`, and the lane gives one pulse per rising edge of that pin.
- R7: The four lanes run independently, each at the period of its own selection, at the same time.
- R8: A new selection written to a running lane takes effect at the old source's next pulse. The interval that ends with that pulse keeps the old length, and the intervals after it have the new length.
- R9: A lane that is off (after reset, or on an unused code) switches at once. When it switches to a table divisor D, its first pulse appears D+2 cycles after the cycle in which the register write was sampled.
- R10: Bank 1 codes 9..13 turn the lane off, and a preload of 0 halts the counter/timer. In both cases no further pulses appear once the switch has settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, nominally 3.6864 MHz |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address: 0..3 lane selectors, 4 timer preload, 5 timer source |
| wrData | input | 16 | Write data |
| extClk | input | 4 | Per-lane external clock pins, asynchronous |
| ctExtClk | input | 1 | Counter/timer external clock pin, asynchronous |
| tick | output | 4 | 16x enables: A receive, A transmit, B receive, B transmit |

## Verification
A wrong divisor count or a wrong source decode shows up at the port as a tick interval that differs from the table value. That difference is visible at the second pulse after the lane settles, which is at most a few thousand cycles at the slowest rate. A pending selection that is applied too early leaves a short interval at the switch point. One that is never applied leaves the old period running. Both are caught within one old period of the write. A timer that keeps running or an off lane that still fires shows up as any pulse at all in a quiet window, and a lane that fires before its first write is visible from reset.

// File: rtl/baudPkg.sv
package baudPkg;

  parameter int NUM_LANES = 4;
  parameter int SEL_W     = 5;
  parameter int DIV_W     = 13;

  localparam logic [3:0] CODE_TIMER = 4'hE;
  localparam logic [3:0] CODE_PIN   = 4'hF;
  localparam logic [SEL_W-1:0] SEL_OFF = 5'h1D;

  typedef enum logic [1:0] {
    SRC_TABLE = 2'd0,
    SRC_TIMER = 2'd1,
    SRC_PIN   = 2'd2,
    SRC_OFF   = 2'd3
  } srcKindT;

  typedef struct packed {
    logic [NUM_LANES-1:0] selWr;
    logic [SEL_W-1:0]     selData;
    logic                 preloadWr;
    logic                 cfgWr;
  } strobeT;

  function automatic srcKindT srcOf(input logic [SEL_W-1:0] sel);
    if (sel[3:0] == CODE_TIMER)                 return SRC_TIMER;
    else if (sel[3:0] == CODE_PIN)              return SRC_PIN;
    else if (sel[4] && (sel[3:0] >= 4'd9))      return SRC_OFF;
    else                                        return SRC_TABLE;
  endfunction

  function automatic logic [DIV_W-1:0] divOf(input logic [SEL_W-1:0] sel);
    logic [DIV_W-1:0] d;
    case (sel)
      5'h00: d = 13'd4608;
      5'h01: d = 13'd3072;
      5'h02: d = 13'd2095;
      5'h03: d = 13'd1713;
      5'h04: d = 13'd1536;
      5'h05: d = 13'd1152;
      5'h06: d = 13'd768;
      5'h07: d = 13'd384;
      5'h08: d = 13'd219;
      5'h09: d = 13'd192;
      5'h0A: d = 13'd128;
      5'h0B: d = 13'd115;
      5'h0C: d = 13'd96;
      5'h0D: d = 13'd48;
      5'h10: d = 13'd32;
      5'h11: d = 13'd24;
      5'h12: d = 13'd16;
      5'h13: d = 13'd12;
      5'h14: d = 13'd8;
      5'h15: d = 13'd6;
      5'h16: d = 13'd4;
      5'h17: d = 13'd3;
      5'h18: d = 13'd2;
      default: d = 13'd1;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/baudCtrl.sv
module baudCtrl
  import baudPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output strobeT            strobe,
  output logic [DATA_W-1:0] preload,
  output logic              timerFromPin
);

  localparam logic [ADDR_W-1:0] ADDR_PRELOAD = ADDR_W'(NUM_LANES);
  localparam logic [ADDR_W-1:0] ADDR_CFG     = ADDR_W'(NUM_LANES + 1);

  strobeT strobeNext;

  always_comb begin
    strobeNext = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      strobeNext.selWr[i] = wrEn && (wrAddr == ADDR_W'(i));
    end
    strobeNext.selData   = wrData[SEL_W-1:0];
    strobeNext.preloadWr = wrEn && (wrAddr == ADDR_PRELOAD);
    strobeNext.cfgWr     = wrEn && (wrAddr == ADDR_CFG);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobe       <= '0;
      preload      <= '0;
      timerFromPin <= 1'b0;
    end else begin
      strobe <= strobeNext;
      if (strobeNext.preloadWr) preload      <= wrData;
      if (strobeNext.cfgWr)     timerFromPin <= wrData[0];
    end
  end

endmodule

// File: rtl/baudLane.sv
module baudLane
  import baudPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             selWr,
  input  logic [SEL_W-1:0] selData,
  input  logic             timerPulse,
  input  logic             pinPulse,
  output logic             tick
);

  logic [SEL_W-1:0] activeSel;
  logic [SEL_W-1:0] pendingSel;
  logic             pendingValid;
  logic [DIV_W-1:0] divCnt;
  srcKindT          activeKind;
  logic             srcPulse;
  logic             switchNow;

  assign activeKind = srcOf(activeSel);

  always_comb begin
    case (activeKind)
      SRC_TABLE: srcPulse = (divCnt == '0);
      SRC_TIMER: srcPulse = timerPulse;
      SRC_PIN:   srcPulse = pinPulse;
      default:   srcPulse = 1'b0;
    endcase
  end

  // switch only on a pulse boundary, or at once when the lane is silent
  assign switchNow = pendingValid && (srcPulse || (activeKind == SRC_OFF));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeSel    <= SEL_OFF;
      pendingSel   <= SEL_OFF;
      pendingValid <= 1'b0;
      divCnt       <= '0;
      tick         <= 1'b0;
    end else begin
      tick <= srcPulse;
      if (switchNow) begin
        activeSel <= pendingSel;
        divCnt    <= divOf(pendingSel) - 1'b1;
      end else if (activeKind == SRC_TABLE) begin
        divCnt <= (divCnt == '0) ? divOf(activeSel) - 1'b1 : divCnt - 1'b1;
      end
      if (selWr) begin
        pendingSel   <= selData;
        pendingValid <= 1'b1;
      end else if (switchNow) begin
        pendingValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/baudDatapath.sv
module baudDatapath
  import baudPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               strobe,
  input  logic [DATA_W-1:0]    preload,
  input  logic                 timerFromPin,
  input  logic [NUM_LANES-1:0] extClk,
  input  logic                 ctExtClk,
  output logic [NUM_LANES-1:0] tick
);

  localparam int PIN_LINES = NUM_LANES + 1;

  logic [PIN_LINES-1:0] pinRaw;
  logic [PIN_LINES-1:0] pinEdge;

  assign pinRaw = {ctExtClk, extClk};

  for (genvar p = 0; p < PIN_LINES; p++) begin : gSync
    logic [SYNC_STAGES:0] shiftR;
    always_ff @(posedge clk) begin
      if (!rstN) shiftR <= '0;
      else       shiftR <= {shiftR[SYNC_STAGES-1:0], pinRaw[p]};
    end
    assign pinEdge[p] = shiftR[SYNC_STAGES-1] & ~shiftR[SYNC_STAGES];
  end

  // shared counter/timer
  logic [DATA_W-1:0] ctCount;
  logic              ctOut;
  logic              ctStep;
  logic              ctLive;
  logic              ctTerm;
  logic              timerPulse;

  assign ctStep     = timerFromPin ? pinEdge[NUM_LANES] : 1'b1;
  assign ctLive     = (preload != '0);
  assign ctTerm     = (ctCount <= DATA_W'(1));
  assign timerPulse = ctStep && ctLive && ctTerm && !ctOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctCount <= '0;
      ctOut   <= 1'b0;
    end else if (ctStep && ctLive) begin
      if (ctTerm) begin
        ctCount <= preload;
        ctOut   <= ~ctOut;
      end else begin
        ctCount <= ctCount - 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : gLane
    baudLane uLane (
      .clk        (clk),
      .rstN       (rstN),
      .selWr      (strobe.selWr[i]),
      .selData    (strobe.selData),
      .timerPulse (timerPulse),
      .pinPulse   (pinEdge[i]),
      .tick       (tick[i])
    );
  end

endmodule

// File: rtl/baudClkGen.sv
module baudClkGen
  import baudPkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_LANES-1:0] extClk,
  input  logic                 ctExtClk,
  output logic [NUM_LANES-1:0] tick
);

  strobeT            strobe;
  logic [DATA_W-1:0] preload;
  logic              timerFromPin;

  baudCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .strobe       (strobe),
    .preload      (preload),
    .timerFromPin (timerFromPin)
  );

  baudDatapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .preload      (preload),
    .timerFromPin (timerFromPin),
    .extClk       (extClk),
    .ctExtClk     (ctExtClk),
    .tick         (tick)
  );

endmodule

// File: rtl/baudClkGenChk.sv
module baudClkGenChk
  import baudPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    wrAddr,
  input logic [DATA_W-1:0]    wrData,
  input logic [NUM_LANES-1:0] tick
);

  logic [NUM_LANES-1:0] written;
  logic [NUM_LANES-1:0] warm;
  logic [NUM_LANES-1:0] lastQuiet;
  logic [NUM_LANES-1:0] quietArm;
  logic [1:0]           age [NUM_LANES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      written   <= '0;
      warm      <= '0;
      lastQuiet <= '0;
      quietArm  <= '0;
      for (int i = 0; i < NUM_LANES; i++) age[i] <= 2'd0;
    end else begin
      for (int i = 0; i < NUM_LANES; i++) begin
        if (wrEn && wrAddr == ADDR_W'(i)) begin
          written[i]   <= 1'b1;
          age[i]       <= 2'd0;
          quietArm[i]  <= 1'b0;
          lastQuiet[i] <= wrData[4] && (wrData[3:0] >= 4'd9) && (wrData[3:0] <= 4'd13);
        end else begin
          if (age[i] != 2'd3) age[i] <= age[i] + 2'd1;
          if (written[i] && age[i] == 2'd3) warm[i] <= 1'b1;
          if (tick[i] && lastQuiet[i] && age[i] == 2'd3) quietArm[i] <= 1'b1;
        end
      end
    end
  end

  AST_UNWRITTEN_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (tick & ~written) == '0);  // R1

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (tick & $past(tick)) == '0);  // R3

  AST_FIRST_TICK_NOT_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    (tick & ~warm) == '0);  // R9

  AST_OFF_CODE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (tick & quietArm) == '0);  // R10

endmodule

bind baudClkGen baudClkGenChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .wrData (wrData),
  .tick   (tick)
);

// File: tb/test_baudClkGen.sv
module test_baudClkGen;

  localparam int LANES = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [3:0]  extClk = '0;
  logic        ctExtClk = 1'b0;
  logic [3:0]  tick;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int tickCnt [LANES];
  int lastTick [LANES];
  int expQ [LANES][$];
  string tagQ [LANES][$];
  int pinHalf = 0;
  int ctHalf = 0;

  baudClkGen i_baudClkGen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extClk(extClk), .ctExtClk(ctExtClk), .tick(tick)
  );

  always #10 clk = ~clk;

  task automatic report(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the expected interval on every tick of an armed lane
  initial begin
    for (int l = 0; l < LANES; l++) begin tickCnt[l] = 0; lastTick[l] = 0; end
    forever begin
      @(negedge clk);
      cyc++;
      for (int l = 0; l < LANES; l++) begin
        if (tick[l]) begin
          if (expQ[l].size() > 0) begin
            int e;
            string t;
            e = expQ[l].pop_front();
            t = tagQ[l].pop_front();
            report((cyc - lastTick[l]) == e, t, cyc - lastTick[l], e);
          end
          lastTick[l] = cyc;
          tickCnt[l]++;
        end
      end
    end
  end

  // external clock generators
  initial begin
    int pc = 0;
    int cc = 0;
    forever begin
      @(negedge clk);
      if (pinHalf > 0) begin
        pc++;
        if (pc >= pinHalf) begin pc = 0; extClk[1] = ~extClk[1]; end
      end
      if (ctHalf > 0) begin
        cc++;
        if (cc >= ctHalf) begin cc = 0; ctExtClk = ~ctExtClk; end
      end
    end
  end

  task automatic writeReg(input int addr, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = 16'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitTicks(input int lane, input int n);
    int target;
    target = tickCnt[lane] + n;
    while (tickCnt[lane] < target) @(negedge clk);
  endtask

  // driver: settle, push expected intervals, wait until the monitor drains them
  task automatic expectPeriod(input int lane, input int per, input int n,
                              input int skip, input string req);
    waitTicks(lane, skip);
    for (int k = 0; k < n; k++) begin
      expQ[lane].push_back(per);
      tagQ[lane].push_back(req);
    end
    while (expQ[lane].size() != 0) @(negedge clk);
  endtask

  task automatic expectQuiet(input int lane, input int window, input string req);
    int base;
    repeat (60) @(negedge clk);
    base = tickCnt[lane];
    repeat (window) @(negedge clk);
    report(tickCnt[lane] == base, req, tickCnt[lane] - base, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state, all lanes silent
    report(tick == 4'b0, "R1 reset outputs", int'(tick), 0);
    repeat (100) @(negedge clk);
    report((tickCnt[0] + tickCnt[1] + tickCnt[2] + tickCnt[3]) == 0, "R1 no tick before write",
           tickCnt[0] + tickCnt[1] + tickCnt[2] + tickCnt[3], 0);

    // R9: off lane switches at once, first tick D+2 cycles after the write
    begin
      int n;
      n = 0;
      writeReg(1, 5'h0D);
      while (!tick[1] && n < 300) begin @(negedge clk); n++; end
      report(n == 50, "R9 first tick latency", n, 50);
    end
    expectPeriod(1, 48, 2, 0, "R2 bank0 code13 period");

    // R2: table divisors
    writeReg(0, 5'h11);
    expectPeriod(0, 24, 3, 2, "R2 9600 period");
    writeReg(0, 5'h00);
    expectPeriod(0, 4608, 2, 2, "R2 50 baud period");

    // R3: fastest rate, pulses one cycle wide
    writeReg(2, 5'h18);
    expectPeriod(2, 2, 4, 2, "R2 bank1 code8 period");
    begin
      int highs;
      highs = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (tick[2]) highs++; end
      report(highs == 10, "R3 single-cycle pulses", highs, 10);
    end

    // R4: counter/timer from the reference clock
    writeReg(4, 5);
    writeReg(3, 5'h0E);
    expectPeriod(3, 10, 3, 3, "R4 preload 5 period");
    writeReg(4, 7);
    expectPeriod(3, 14, 3, 3, "R4 preload 7 period");

    // R5: counter/timer counts edges of its pin
    ctHalf = 3;
    writeReg(4, 2);
    writeReg(5, 1);
    expectPeriod(3, 24, 2, 3, "R5 timer on pin period");

    // R6: lane pin source
    pinHalf = 5;
    writeReg(1, 5'h0F);
    expectPeriod(1, 10, 3, 3, "R6 pin source period");

    // R7: all lanes concurrently at their own rates
    writeReg(0, 5'h11);
    fork
      expectPeriod(0, 24, 3, 3, "R7 lane0 concurrent");
      expectPeriod(1, 10, 3, 3, "R7 lane1 concurrent");
      expectPeriod(2, 2, 3, 3, "R7 lane2 concurrent");
      expectPeriod(3, 24, 3, 3, "R7 lane3 concurrent");
    join

    // R8: change takes effect at the old source's next pulse
    writeReg(0, 5'h0C);
    waitTicks(0, 3);
    expQ[0].push_back(96); tagQ[0].push_back("R8 old interval kept");
    expQ[0].push_back(24); tagQ[0].push_back("R8 new interval");
    expQ[0].push_back(24); tagQ[0].push_back("R8 new interval");
    writeReg(0, 5'h11);
    while (expQ[0].size() != 0) @(negedge clk);

    // R10: unused code and zero preload are silent
    writeReg(2, 5'h1B);
    expectQuiet(2, 200, "R10 unused code silent");
    writeReg(4, 0);
    expectQuiet(3, 200, "R10 zero preload halts timer");
    expectPeriod(0, 24, 2, 1, "R7 lane0 unaffected");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule